// File: doc/BRIEF.md
# Processor Exception Vector Classifier

This unit sits beside the issue/completion stage of a processor whose instructions start with a 16-bit opword. Each cycle in which an instruction completes, it looks at the first opword, the decoder's legality verdict, the privilege, halt and stop indications, a zero-divisor flag, the current mode, the trace status bit and a debug bit that lets user code run HALT. From these it decides whether an exception is due and which vector it uses.

One clock edge after a completion it produces a one-cycle request strobe, together with the vector number, the byte offset of that vector in the vector table, and a flag that selects which PC goes into the stacked frame: the faulting instruction's PC or the next instruction's PC. Only the first opword is classified. Extension words never reach this unit. Decoding, frame stacking and the vector fetch are done elsewhere.

Top module: `exc_vector_classifier`

## Requirements
- R1: A completion with `op_legal`=0 whose opword bits [15:12] are neither 0xA nor 0xF raises vector 4 with `exc_pc_next`=0.
- R2: A completion with `op_legal`=0 and opword bits [15:12]=0xA raises vector 10 with `exc_pc_next`=0.
- R3: A completion with `op_legal`=0 and opword bits [15:12]=0xF raises vector 11 with `exc_pc_next`=0.
- R4: When `op_legal`=1, no illegal-class vector (4, 10, 11) is raised for any opword value, including lines 0xA and 0xF.
- R5: A completion with `div_zero`=1 raises vector 5 at offset 0x014 with `exc_pc_next`=0.
- R6: A completion with `op_priv`=1 while `sup_mode`=0 raises vector 8 with `exc_pc_next`=0. With `sup_mode`=1 the same completion raises no privilege violation.
- R7: A HALT (`op_halt`=1, `op_priv`=1) completing in user mode raises no privilege violation when `dbg_uhalt_en`=1.
- R8: With `trace_en`=1, a completion that raises no other exception and is not STOP raises vector 9 with `exc_pc_next`=1. For the instruction just before STOP, that PC is the STOP opword's address.
- R9: A STOP completion (`op_stop`=1) never raises the trace vector, even when `trace_en`=1.
- R10: `exc_off` always equals `exc_vec` times four, as a 10-bit byte offset.
- R11: When several conditions are present at once, the priority order is: illegal class (R1 to R3), then privilege violation, then divide-by-zero, then trace.
- R12: `exc_req` is high for exactly the cycle after a completion that raises an exception, and is low otherwise. Synchronous reset clears `exc_req`, `exc_vec`, `exc_off` and `exc_pc_next` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_valid | input | 1 | An instruction completes this cycle |
| opword | input | 16 | First opword of that instruction |
| op_legal | input | 1 | Decoder judged the opword legal |
| op_priv | input | 1 | Instruction is supervisor-only |
| op_halt | input | 1 | Instruction is HALT |
| op_stop | input | 1 | Instruction is STOP |
| div_zero | input | 1 | Divide with zero divisor |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| trace_en | input | 1 | Trace status bit |
| dbg_uhalt_en | input | 1 | Debug permission for HALT in user mode |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 8 | Vector number |
| exc_off | output | 10 | Vector table byte offset |
| exc_pc_next | output | 1 | 1 = stack next PC, 0 = stack faulting PC |

## Verification
Every result of this block is due exactly one clock edge after the completion cycle. The vector, offset, PC select and strobe are all registered together on that edge. The bench drives each completion on a falling edge and samples all four outputs on the following falling edge, so every sample falls one rising edge after its stimulus. It then drops `cmpl_valid` for one cycle and checks that the strobe has fallen again. The vector, offset and PC select are compared only in cycles where a request is expected. In all other cycles the bench requires the strobe to be low.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;
  typedef enum logic [2:0] {
    C_NONE, C_ILL, C_LINEA, C_LINEF, C_PRIV, C_DIVZ, C_TRACE
  } cause_e;

  localparam int VEC_ILLEGAL = 4;
  localparam int VEC_DIVZ    = 5;
  localparam int VEC_PRIV    = 8;
  localparam int VEC_TRACE   = 9;
  localparam int VEC_LINEA   = 10;
  localparam int VEC_LINEF   = 11;

  function automatic int cause_vec(cause_e c);
    case (c)
      C_ILL:   return VEC_ILLEGAL;
      C_LINEA: return VEC_LINEA;
      C_LINEF: return VEC_LINEF;
      C_PRIV:  return VEC_PRIV;
      C_DIVZ:  return VEC_DIVZ;
      C_TRACE: return VEC_TRACE;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/exc_fault_detect.sv
module exc_fault_detect
  import exc_cls_pkg::*;
#(
  parameter int OPW_W  = 16,
  parameter int LINE_W = 4
) (
  input  logic [OPW_W-1:0] opword,
  input  logic             op_legal,
  input  logic             op_priv,
  input  logic             op_halt,
  input  logic             sup_mode,
  input  logic             dbg_uhalt_en,
  output cause_e           ill_cls,
  output logic             priv_viol
);
  localparam logic [LINE_W-1:0] LINE_A = LINE_W'(4'hA);
  localparam logic [LINE_W-1:0] LINE_F = LINE_W'(4'hF);

  logic [LINE_W-1:0] line;
  logic              halt_allowed;

  assign line = opword[OPW_W-1 -: LINE_W];

  always_comb begin
    ill_cls = C_NONE;
    if (!op_legal) begin
      if (line == LINE_A)      ill_cls = C_LINEA;
      else if (line == LINE_F) ill_cls = C_LINEF;
      else                     ill_cls = C_ILL;
    end
  end

  assign halt_allowed = op_halt && dbg_uhalt_en;
  assign priv_viol    = op_priv && !sup_mode && !halt_allowed;
endmodule

// File: rtl/exc_prio_encode.sv
module exc_prio_encode
  import exc_cls_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  cause_e           ill_cls,
  input  logic             priv_viol,
  input  logic             div_zero,
  input  logic             trace_en,
  input  logic             op_stop,
  output logic             hit,
  output logic [VEC_W-1:0] vec,
  output logic [VEC_W+1:0] off,
  output logic             pc_next
);
  cause_e win;

  always_comb begin
    if (ill_cls != C_NONE)        win = ill_cls;
    else if (priv_viol)           win = C_PRIV;
    else if (div_zero)            win = C_DIVZ;
    else if (trace_en && !op_stop) win = C_TRACE;
    else                          win = C_NONE;
  end

  assign hit     = (win != C_NONE);
  assign vec     = VEC_W'(cause_vec(win));
  assign off     = (VEC_W + 2)'(cause_vec(win) * 4);
  assign pc_next = (win == C_TRACE);
endmodule

// File: rtl/exc_vector_classifier.sv
module exc_vector_classifier
  import exc_cls_pkg::*;
#(
  parameter int OPW_W  = 16,
  parameter int LINE_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpl_valid,
  input  logic [OPW_W-1:0] opword,
  input  logic             op_legal,
  input  logic             op_priv,
  input  logic             op_halt,
  input  logic             op_stop,
  input  logic             div_zero,
  input  logic             sup_mode,
  input  logic             trace_en,
  input  logic             dbg_uhalt_en,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec,
  output logic [VEC_W+1:0] exc_off,
  output logic             exc_pc_next
);
  localparam int OFF_W = VEC_W + 2;

  cause_e           ill_cls;
  logic             priv_viol;
  logic             hit;
  logic [VEC_W-1:0] nxt_vec;
  logic [OFF_W-1:0] nxt_off;
  logic             nxt_pc_next;

  exc_fault_detect #(.OPW_W(OPW_W), .LINE_W(LINE_W)) u_det (
    .opword(opword), .op_legal(op_legal), .op_priv(op_priv),
    .op_halt(op_halt), .sup_mode(sup_mode), .dbg_uhalt_en(dbg_uhalt_en),
    .ill_cls(ill_cls), .priv_viol(priv_viol)
  );

  exc_prio_encode #(.VEC_W(VEC_W)) u_prio (
    .ill_cls(ill_cls), .priv_viol(priv_viol), .div_zero(div_zero),
    .trace_en(trace_en), .op_stop(op_stop), .hit(hit), .vec(nxt_vec),
    .off(nxt_off), .pc_next(nxt_pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req     <= 1'b0;
      exc_vec     <= '0;
      exc_off     <= '0;
      exc_pc_next <= 1'b0;
    end else begin
      exc_req <= cmpl_valid && hit;
      if (cmpl_valid && hit) begin
        exc_vec     <= nxt_vec;
        exc_off     <= nxt_off;
        exc_pc_next <= nxt_pc_next;
      end
    end
  end

  // R10
  a_r10_offset: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_off == {exc_vec, 2'b00}));
  // R12
  a_r12_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(cmpl_valid));
  // R1
  a_r1_illegal_src: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_vec == VEC_W'(VEC_ILLEGAL)) |-> !$past(op_legal));
  // R6
  a_r6_priv_user: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_vec == VEC_W'(VEC_PRIV)) |-> !$past(sup_mode));
  // R7
  a_r7_uhalt: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_vec == VEC_W'(VEC_PRIV)) |-> !($past(op_halt) && $past(dbg_uhalt_en)));
  // R8
  a_r8_trace_pc: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_vec == VEC_W'(VEC_TRACE)) |-> exc_pc_next);
  // R9
  a_r9_no_stop_trace: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_vec == VEC_W'(VEC_TRACE)) |-> !$past(op_stop));
endmodule

// File: tb/sim_exc_vector_classifier.sv
module sim_exc_vector_classifier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpl_valid = 0, op_legal = 1, op_priv = 0, op_halt = 0, op_stop = 0;
  logic div_zero = 0, sup_mode = 1, trace_en = 0, dbg_uhalt_en = 0;
  logic [15:0] opword = '0;
  logic        exc_req, exc_pc_next;
  logic [7:0]  exc_vec;
  logic [9:0]  exc_off;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_vector_classifier u0 (
    .clk(clk), .rst(rst), .cmpl_valid(cmpl_valid), .opword(opword),
    .op_legal(op_legal), .op_priv(op_priv), .op_halt(op_halt),
    .op_stop(op_stop), .div_zero(div_zero), .sup_mode(sup_mode),
    .trace_en(trace_en), .dbg_uhalt_en(dbg_uhalt_en), .exc_req(exc_req),
    .exc_vec(exc_vec), .exc_off(exc_off), .exc_pc_next(exc_pc_next)
  );

  // expected vector (0 = none) and tag, from the requirements
  function automatic int exp_vec(output string tag);
    if (!op_legal && opword[15:12] == 4'hA) begin tag = "R2"; return 10; end
    if (!op_legal && opword[15:12] == 4'hF) begin tag = "R3"; return 11; end
    if (!op_legal)                          begin tag = "R1"; return 4; end
    if (op_priv && !sup_mode && !(op_halt && dbg_uhalt_en)) begin tag = "R6"; return 8; end
    if (div_zero)                           begin tag = "R5"; return 5; end
    if (trace_en && !op_stop)               begin tag = "R8"; return 9; end
    tag = "R9/R7/R4 no-exception";
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ow, input logic lg, input logic pv,
                       input logic hl, input logic sp, input logic dz,
                       input logic sm, input logic tr, input logic uh);
    string tag;
    int ev;
    @(negedge clk);
    opword = ow; op_legal = lg; op_priv = pv; op_halt = hl; op_stop = sp;
    div_zero = dz; sup_mode = sm; trace_en = tr; dbg_uhalt_en = uh;
    cmpl_valid = 1;
    ev = exp_vec(tag);
    @(negedge clk);
    cmpl_valid = 0;
    check(exc_req == (ev != 0), tag, "exc_req", int'(exc_req), int'(ev != 0));
    if (ev != 0) begin
      check(exc_vec == 8'(ev), tag, "exc_vec", int'(exc_vec), ev);
      check(exc_off == 10'(ev * 4), "R10", "exc_off", int'(exc_off), ev * 4);
      check(exc_pc_next == (ev == 9), tag, "exc_pc_next", int'(exc_pc_next), int'(ev == 9));
    end
    @(negedge clk);
    check(exc_req == 1'b0, "R12", "exc_req idle", int'(exc_req), 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(exc_req == 0 && exc_vec == 0 && exc_off == 0 && exc_pc_next == 0,
          "R12", "reset outputs", int'(exc_req), 0);
    rst = 0;
    // directed corners: ow lg pv hl sp dz sm tr uh
    apply(16'h4AFC, 0, 0, 0, 0, 0, 1, 0, 0); // R1
    apply(16'hA123, 0, 0, 0, 0, 0, 1, 0, 0); // R2
    apply(16'hF800, 0, 0, 0, 0, 0, 1, 0, 0); // R3
    apply(16'hA123, 1, 0, 0, 0, 0, 1, 0, 0); // R4 legal line A
    apply(16'hF800, 1, 0, 0, 0, 0, 1, 0, 0); // R4 legal line F
    apply(16'h4C40, 1, 0, 0, 0, 1, 1, 0, 0); // R5
    apply(16'h46FC, 1, 1, 0, 0, 0, 0, 0, 0); // R6 user
    apply(16'h46FC, 1, 1, 0, 0, 0, 1, 0, 0); // R6 supervisor
    apply(16'h4AC8, 1, 1, 1, 0, 0, 0, 0, 1); // R7 halt allowed
    apply(16'h4AC8, 1, 1, 1, 0, 0, 0, 0, 0); // R7 halt blocked
    apply(16'h4E71, 1, 0, 0, 0, 0, 1, 1, 0); // R8 instruction before STOP
    apply(16'h4E72, 1, 1, 0, 1, 0, 1, 1, 0); // R9 STOP under trace
    apply(16'hF000, 0, 1, 0, 0, 1, 0, 1, 0); // R11 all at once
    apply(16'h46FC, 1, 1, 0, 0, 1, 0, 1, 0); // R11 priv over divz
    apply(16'h4C40, 1, 0, 0, 0, 1, 1, 1, 0); // R11 divz over trace
    // back-to-back completions, R12
    @(negedge clk);
    opword = 16'h1000; op_legal = 1; op_priv = 0; op_halt = 0; op_stop = 0;
    div_zero = 0; sup_mode = 1; trace_en = 1; dbg_uhalt_en = 0; cmpl_valid = 1;
    @(negedge clk);
    check(exc_req == 1 && exc_vec == 9, "R12", "b2b first", int'(exc_vec), 9);
    @(negedge clk);
    cmpl_valid = 0;
    check(exc_req == 1 && exc_vec == 9, "R12", "b2b second", int'(exc_vec), 9);
    @(negedge clk);
    check(exc_req == 0, "R12", "b2b end", int'(exc_req), 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ow;
      logic [3:0] ln;
      int sel;
      sel = $urandom_range(0, 3);
      ln = (sel == 0) ? 4'hA : (sel == 1) ? 4'hF : 4'($urandom);
      ow = {ln, 12'($urandom)};
      apply(ow, ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 4) == 0), ($urandom_range(0, 3) == 0),
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule